// File: doc/BRIEF.md
# MSI Shared Interrupt Register Controller

This block collects message-signalled interrupts and turns them into four level interrupt lines. A message arrives as one data byte on a simple write strobe. The two low bits of the byte pick one of four shared pending registers. The field above them picks a bit position inside that register. The chosen bit is set, and it stays set until software reads the register.

Each register drives its own interrupt output. That output is high while the register holds any pending bit. Software reads a register by naming it on the read port. The read returns the pending bits and clears them in the same step.

A parameter selects the width of the bit-select field:
- **Wide variant:** 5 bits, which address 32 register positions.
- **Narrow variant:** 3 bits, which address 8 register positions.

Bit-select values count down from the top implemented bit, so value 0 always lands on the highest bit of the register.

Top module: `msi_share_ctrl`

## Requirements
- R1: Synchronous active-high `rst` clears all four registers, drives `irq_out` to 0 and drives `rd_data` to 0.
- R2: When `msg_valid` is high, `msg_data[1:0]` selects register 0..3, and only that register changes.
- R3: In the wide variant (`WIDE_SEL`=1), the value i in `msg_data[6:2]` sets register bit 31−i.
- R4: In the narrow variant (`WIDE_SEL`=0), the value i in `msg_data[4:2]` sets register bit 7−i. `msg_data[6:5]` has no effect, and register bits 31:8 always read as 0.
- R5: `msg_data[7]` has no effect on which register or bit is set.
- R6: `irq_out[k]` is high in the cycle after a write to register k, and it stays high while register k is nonzero.
- R7: A read with `rd_en` high and `rd_sel`=k places register k on `rd_data` one cycle later. The same read clears exactly the bits it returned, and bits written earlier accumulate until they are read.
- R8: A message that sets a bit in the same cycle as a read of that register leaves that bit pending after the read.
- R9: Writing a bit that is already pending leaves it set once: one read returns it, and the next read returns 0.
- R10: While `msg_valid` is low, `msg_data` has no effect.
- R11: `rd_data` holds the last value read until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message write strobe |
| msg_data | input | 8 | Message byte: bits 1:0 select the register, the field above them selects the bit |
| rd_en | input | 1 | Read-and-clear strobe |
| rd_sel | input | 2 | Register to read |
| rd_data | output | 32 | Pending bits returned by the last read |
| irq_out | output | 4 | One level interrupt per register |

## Verification
A message written at one clock edge is visible from the following cycle, on both `irq_out` and the register contents. A read issued at an edge presents its data on `rd_data` in the following cycle, and it lowers the interrupt line in that same cycle unless a message sets a bit in the same register at the same edge. The bench changes inputs on falling edges and samples outputs on the next falling edge, so every result is checked exactly one register stage after the stimulus that caused it. Both variants are driven with identical stimulus, and the expected narrow-variant bit position is computed from the byte.

// File: rtl/msi_share_pkg.sv
package msi_share_pkg;
    localparam int NUM_GRP = 4;
    localparam int SEL_W   = 2;
    localparam int REG_W   = 32;
    localparam int MSG_W   = 8;

    typedef logic [SEL_W-1:0] grp_t;
    typedef logic [REG_W-1:0] vec_t;

    typedef struct packed {
        logic hit;
        grp_t grp;
        vec_t bitvec;
    } set_req_t;

    function automatic int field_width(input bit wide);
        return wide ? 5 : 3;
    endfunction
endpackage

// File: rtl/msi_share_decode.sv
module msi_share_decode
    import msi_share_pkg::*;
#(
    parameter int IBS_W = 5
) (
    input  logic             valid,
    input  logic [MSG_W-1:0] data,
    output set_req_t         req
);
    localparam int NBITS = 1 << IBS_W;

    logic [IBS_W-1:0] ibs;
    logic [4:0]       pos;
    logic             unused_bits;

    assign ibs         = data[SEL_W +: IBS_W];
    assign pos         = 5'(NBITS - 1) - 5'(ibs);
    assign unused_bits = ^data[MSG_W-1:SEL_W+IBS_W];

    always_comb begin
        req        = '0;
        req.hit    = valid;
        req.grp    = data[SEL_W-1:0];
        if (valid) req.bitvec = vec_t'(1) << pos;
    end
endmodule

// File: rtl/msi_share_bank.sv
module msi_share_bank
    import msi_share_pkg::*;
#(
    parameter int NBITS = 32
) (
    input  logic clk,
    input  logic rst,
    input  vec_t set_vec,
    input  logic rd_hit,
    output vec_t pend,
    output logic irq
);
    vec_t keep;

    assign keep = rd_hit ? '0 : pend;
    assign irq  = |pend;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= keep | set_vec;
    end

    // R7 / R8: after a read only the bits set in that same cycle remain
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> pend == $past(set_vec));

    // R9: a set bit stays set
    a_r9_set_sticks: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

    // R10: no read and no write leave the register untouched
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!rd_hit && set_vec == '0) |=> $stable(pend));

    generate
        if (NBITS < REG_W) begin : g_narrow
            // R4: unimplemented upper bits stay zero
            a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
                pend[REG_W-1:NBITS] == '0);
        end
    endgenerate
endmodule

// File: rtl/msi_share_ctrl.sv
module msi_share_ctrl
    import msi_share_pkg::*;
#(
    parameter bit WIDE_SEL = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        msg_valid,
    input  logic [7:0]  msg_data,
    input  logic        rd_en,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic [3:0]  irq_out
);
    localparam int IBS_W = field_width(WIDE_SEL);
    localparam int NBITS = 1 << IBS_W;

    set_req_t req;
    vec_t     pend [NUM_GRP];

    msi_share_decode #(.IBS_W(IBS_W)) u_dec (
        .valid (msg_valid),
        .data  (msg_data),
        .req   (req)
    );

    // R2: one-hot set request
    a_r2_one_bit: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> $countones(req.bitvec) == 1);

    generate
        for (genvar k = 0; k < NUM_GRP; k++) begin : g_bank
            vec_t set_k;
            logic rd_k;
            assign set_k = (req.hit && req.grp == grp_t'(k)) ? req.bitvec : '0;
            assign rd_k  = rd_en && rd_sel == grp_t'(k);
            msi_share_bank #(.NBITS(NBITS)) u_bank (
                .clk     (clk),
                .rst     (rst),
                .set_vec (set_k),
                .rd_hit  (rd_k),
                .pend    (pend[k]),
                .irq     (irq_out[k])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= pend[rd_sel];
    end

    // R11: output only changes on a read
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R6: a write to register k raises its line next cycle
    a_r6_irq_rise: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> irq_out[$past(msg_data[1:0])]);
endmodule

// File: tb/msi_share_ctrl_test.sv
module msi_share_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msg_valid = 1'b0;
    logic [7:0]  msg_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_w, rd_n;
    logic [3:0]  irq_w, irq_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_share_ctrl #(.WIDE_SEL(1'b1)) uut (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_data(msg_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_w), .irq_out(irq_w));

    msi_share_ctrl #(.WIDE_SEL(1'b0)) uut_narrow (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_data(msg_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_n), .irq_out(irq_n));

    // {message byte, register, expected wide-variant bit mask}
    localparam logic [41:0] VEC [8] = '{
        {8'h00, 2'd0, 32'h8000_0000},
        {8'h7F, 2'd3, 32'h0000_0001},
        {8'h05, 2'd1, 32'h4000_0000},
        {8'h8A, 2'd2, 32'h2000_0000},
        {8'h42, 2'd2, 32'h0000_8000},
        {8'h3C, 2'd0, 32'h0001_0000},
        {8'hFD, 2'd1, 32'h0000_0001},
        {8'h1B, 2'd3, 32'h0200_0000}
    };

    function automatic logic [31:0] narrow_mask(input logic [7:0] b);
        return 32'd1 << (7 - int'(b[4:2]));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        msg_valid = 1'b1;
        msg_data  = b;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s);
        @(negedge clk);
        rd_en  = 1'b1;
        rd_sel = s;
        @(negedge clk);
        rd_en  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 wide rd_data", rd_w, 32'h0);
        check("R1 wide irq", {28'h0, irq_w}, 32'h0);
        check("R1 narrow rd_data", rd_n, 32'h0);
        check("R1 narrow irq", {28'h0, irq_n}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < 8; i++) begin
            logic [7:0]  b;
            logic [1:0]  s;
            logic [31:0] m;
            {b, s, m} = VEC[i];
            wr(b);
            check("R6 R2 wide irq", {28'h0, irq_w}, 32'd1 << s);
            check("R6 R2 narrow irq", {28'h0, irq_n}, 32'd1 << s);
            rd(s + 2'd1);
            check("R2 other register wide", rd_w, 32'h0);
            rd(s);
            check("R3 R5 wide bit", rd_w, m);
            check("R4 R5 narrow bit", rd_n, narrow_mask(b));
            check("R7 wide irq cleared", {28'h0, irq_w}, 32'h0);
            check("R7 narrow irq cleared", {28'h0, irq_n}, 32'h0);
        end

        // R10: data without valid
        @(negedge clk);
        msg_data = 8'h00;
        @(negedge clk);
        check("R10 irq idle", {28'h0, irq_w}, 32'h0);
        rd(2'd0);
        check("R10 no effect", rd_w, 32'h0);

        // R7: accumulation of two bits
        wr(8'h00);
        wr(8'h04);
        rd(2'd0);
        check("R7 accumulate wide", rd_w, 32'hC000_0000);
        check("R7 accumulate narrow", rd_n, 32'h0000_00C0);

        // R11: hold after read
        repeat (3) @(negedge clk);
        check("R11 hold wide", rd_w, 32'hC000_0000);

        // R9: duplicate write
        wr(8'h05);
        wr(8'h05);
        rd(2'd1);
        check("R9 first read", rd_w, 32'h4000_0000);
        rd(2'd1);
        check("R9 second read", rd_w, 32'h0);

        // R8: write during read of the same bit
        wr(8'h00);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = 2'd0;
        msg_valid = 1'b1; msg_data = 8'h00;
        @(negedge clk);
        rd_en = 1'b0; msg_valid = 1'b0;
        check("R8 read data", rd_w, 32'h8000_0000);
        check("R8 irq stays", {28'h0, irq_w}, 32'h1);
        rd(2'd0);
        check("R8 bit survived", rd_w, 32'h8000_0000);

        // R1: reset mid-run
        wr(8'h7F);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset irq", {28'h0, irq_w}, 32'h0);
        check("R1 reset rd_data", rd_w, 32'h0);
        rd(2'd3);
        check("R1 reset cleared", rd_w, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule